// File: doc/BRIEF.md
# Halting Debug Control and Status Register

This block is a single 32-bit memory-mapped register through which a debug host turns on halting debug, asks the core to halt or to execute one instruction, and masks the configurable, system-tick and pend-service interrupts while the core is stopped. The same register, when read, reports live core status (transfer ready, halted, sleeping, locked up) and two sticky event flags (an instruction retired, a reset occurred) that are cleared by the read itself.

Accesses arrive on a plain select/write/read bus with a tag that marks accesses coming from the debugger port as distinct from software running on the core. Every write must carry a 16-bit key in its upper half. Only a debugger-port access may turn debug on, and the interrupt mask may only move while the core is already halted. The four control outputs drive the core's halt logic and interrupt controller. The non-maskable interrupt is not wired through this block and is never masked.

Top module: `dhc_halt_regfile`

## Requirements
- R1: A write (bus_sel=1, bus_wr=1) updates the control bits only when bus_wdata[31:16] equals 16'hA05F; with any other key value the whole write is ignored.
- R2: Control bit positions are bit 0 debug enable, bit 1 halt, bit 2 step, bit 3 interrupt mask; a read returns the stored control values in bits [3:0], and the key field bits [31:16] carry status only (never the key).
- R3: The debug enable can go from 0 to 1 only through a keyed write with bus_from_dap=1; a software write (bus_from_dap=0) can clear it but not set it.
- R4: A keyed write changes the stored interrupt mask only if the stored halt bit was already 1 before the write and the write's bit 1 is also 1; otherwise the mask keeps its value.
- R5: Read bit 24 is a sticky retired flag and bit 25 a sticky reset-event flag; each is set by its event input and cleared by a read (bus_sel=1, bus_rd=1), the read itself returning the value held before the clear.
- R6: An event arriving in the same cycle as a read leaves its sticky flag at 1.
- R7: halt_req, step_req and irq_mask are 0 whenever debug_en is 0, whatever the stored bits hold.
- R8: Read bits 16, 17 and 18 return xfer_ready, core_halted and core_sleeping; bit 19 returns core_lockup but reads 0 while core_halted is 1; all other unnamed bits read 0.
- R9: After reset all control bits and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register selected this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears sticky flags) |
| bus_from_dap | input | 1 | Access originates from the debugger port |
| bus_wdata | input | 32 | Write data, key in [31:16] |
| bus_rdata | output | 32 | Read data (combinational view) |
| xfer_ready | input | 1 | Core register transfer complete |
| core_halted | input | 1 | Core is in debug state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_retired | input | 1 | An instruction retired this cycle |
| core_reset_evt | input | 1 | A core reset occurred this cycle |
| debug_en | output | 1 | Halting debug enabled |
| halt_req | output | 1 | Halt request to the core |
| step_req | output | 1 | Single-step request to the core |
| irq_mask | output | 1 | Mask for configurable, system-tick and pend-service interrupts |

## Verification
The assertions watch, on every cycle, that an unkeyed write leaves the control bits unchanged, that debug enable never rises without a keyed debugger-port write, that the mask never moves outside a halted keyed write, and that sticky flags neither drop without a read nor miss an event. Only the bench scenarios show the exact read-back word, the lockup masking while halted, the read-returns-old-value behaviour of the sticky flags and the forcing of outputs when debug is off, by comparing each read and every output against a behavioural model.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_LSB  = 16;
  localparam int KEY_W    = 16;

  localparam int B_EN     = 0;
  localparam int B_HALT   = 1;
  localparam int B_STEP   = 2;
  localparam int B_MASK   = 3;
  localparam int B_RDY    = 16;
  localparam int B_HLTD   = 17;
  localparam int B_SLP    = 18;
  localparam int B_LOCK   = 19;
  localparam int B_RET    = 24;
  localparam int B_RST    = 25;

  localparam int N_STICKY = 2;
  localparam int S_RET    = 0;
  localparam int S_RST    = 1;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dhc_ctrl_bits.sv
module dhc_ctrl_bits
  import dhc_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              from_dap,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  key_ok;
  logic  wr_ok;
  logic  mask_ok;
  logic  unused_wbits;

  assign key_ok       = (wdata[KEY_LSB +: KEY_W] == KEY);
  assign wr_ok        = wr_hit & key_ok;
  assign mask_ok      = wr_ok & ctrl_q.halt & wdata[B_HALT];
  assign unused_wbits = ^wdata[KEY_LSB-1:B_MASK+1];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) begin
      ctrl_d.en   = wdata[B_EN] & (ctrl_q.en | from_dap);
      ctrl_d.halt = wdata[B_HALT];
      ctrl_d.step = wdata[B_STEP];
    end
    if (mask_ok) begin
      ctrl_d.mask = wdata[B_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_key_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wdata[KEY_LSB +: KEY_W] != KEY)) |=> $stable(ctrl_q));

  assert_sw_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !(wr_hit && from_dap)) |=> !ctrl_q.en);

  assert_mask_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && key_ok && ctrl_q.halt && wdata[B_HALT]) |=> $stable(ctrl_q.mask));
endmodule

// File: rtl/dhc_sticky.sv
module dhc_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d;
    always_comb d = evt[i] | (q & ~clr);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags[i] = q;

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> q);
  end
endmodule

// File: rtl/dhc_status_view.sv
module dhc_status_view
  import dhc_pkg::*;
(
  input  ctrl_t                ctrl,
  input  logic [N_STICKY-1:0]  flags,
  input  logic                 xfer_ready,
  input  logic                 core_halted,
  input  logic                 core_sleeping,
  input  logic                 core_lockup,
  output logic [DATA_W-1:0]    rdata
);
  always_comb begin
    rdata          = '0;
    rdata[B_EN]    = ctrl.en;
    rdata[B_HALT]  = ctrl.halt;
    rdata[B_STEP]  = ctrl.step;
    rdata[B_MASK]  = ctrl.mask;
    rdata[B_RDY]   = xfer_ready;
    rdata[B_HLTD]  = core_halted;
    rdata[B_SLP]   = core_sleeping;
    rdata[B_LOCK]  = core_lockup & ~core_halted;
    rdata[B_RET]   = flags[S_RET];
    rdata[B_RST]   = flags[S_RST];
  end
endmodule

// File: rtl/dhc_halt_regfile.sv
module dhc_halt_regfile
  import dhc_pkg::*;
#(
  parameter logic [15:0] KEY = 16'hA05F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_from_dap,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        xfer_ready,
  input  logic        core_halted,
  input  logic        core_sleeping,
  input  logic        core_lockup,
  input  logic        core_retired,
  input  logic        core_reset_evt,
  output logic        debug_en,
  output logic        halt_req,
  output logic        step_req,
  output logic        irq_mask
);
  ctrl_t               ctrl;
  logic [N_STICKY-1:0] flags;
  logic [N_STICKY-1:0] evts;
  logic                wr_hit;
  logic                rd_hit;

  assign wr_hit       = bus_sel & bus_wr;
  assign rd_hit       = bus_sel & bus_rd;
  assign evts[S_RET]  = core_retired;
  assign evts[S_RST]  = core_reset_evt;

  dhc_ctrl_bits #(.KEY(KEY)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .from_dap (bus_from_dap),
    .wdata    (bus_wdata),
    .ctrl_o   (ctrl)
  );

  dhc_sticky #(.N(N_STICKY)) sticky_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evts),
    .clr   (rd_hit),
    .flags (flags)
  );

  dhc_status_view view_i (
    .ctrl          (ctrl),
    .flags         (flags),
    .xfer_ready    (xfer_ready),
    .core_halted   (core_halted),
    .core_sleeping (core_sleeping),
    .core_lockup   (core_lockup),
    .rdata         (bus_rdata)
  );

  assign debug_en = ctrl.en;
  assign halt_req = ctrl.en & ctrl.halt;
  assign step_req = ctrl.en & ctrl.step;
  assign irq_mask = ctrl.en & ctrl.mask;

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!debug_en && flags == '0));
endmodule

// File: tb/dhc_halt_regfile_tb_top.sv
`timescale 1ns/1ps
module dhc_halt_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_rd, bus_from_dap;
  logic [31:0] bus_wdata, bus_rdata;
  logic        xfer_ready, core_halted, core_sleeping, core_lockup;
  logic        core_retired, core_reset_evt;
  logic        debug_en, halt_req, step_req, irq_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_en, m_halt, m_step, m_mask, m_ret, m_rst;

  always #5 clk = ~clk;

  dhc_halt_regfile dut_i (.*);

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    v[0] = m_en; v[1] = m_halt; v[2] = m_step; v[3] = m_mask;
    v[16] = xfer_ready; v[17] = core_halted; v[18] = core_sleeping;
    v[19] = core_lockup & ~core_halted;
    v[24] = m_ret; v[25] = m_rst;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: inputs set after a falling edge, read data checked
  // before the rising edge, model updated at it, outputs checked after.
  task automatic tick(input string req);
    bit wr_ok, rd;
    #1;
    rd = bus_sel & bus_rd;
    if (rd) check({req, " rdata"}, bus_rdata, exp_rdata());
    @(posedge clk);
    wr_ok = bus_sel & bus_wr & (bus_wdata[31:16] == 16'hA05F);
    if (wr_ok) begin
      if (m_halt && bus_wdata[1]) m_mask = bus_wdata[3];
      m_en   = bus_wdata[0] & (m_en | bus_from_dap);
      m_halt = bus_wdata[1];
      m_step = bus_wdata[2];
    end
    m_ret = core_retired   | (m_ret & ~rd);
    m_rst = core_reset_evt | (m_rst & ~rd);
    @(negedge clk);
    check({req, " outputs (R7)"}, {28'd0, debug_en, halt_req, step_req, irq_mask},
          {28'd0, m_en, m_en & m_halt, m_en & m_step, m_en & m_mask});
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_from_dap = 0; bus_wdata = '0;
    core_retired = 0; core_reset_evt = 0;
  endtask

  task automatic wr(input logic [31:0] d, input bit dap, input string req);
    bus_sel = 1; bus_wr = 1; bus_wdata = d; bus_from_dap = dap;
    tick(req);
  endtask

  task automatic rd(input string req);
    bus_sel = 1; bus_rd = 1;
    tick(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_from_dap = 0; bus_wdata = '0;
    xfer_ready = 0; core_halted = 0; core_sleeping = 0; core_lockup = 0;
    core_retired = 0; core_reset_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset outputs", {debug_en, halt_req, step_req, irq_mask}, 4'b0);
    rd("R9 reset read");

    wr(32'h1234_000F, 1, "R1 wrong key");
    rd("R1 wrong key ignored");
    wr(32'h0000_0003, 1, "R1 zero key");
    rd("R1 zero key ignored");

    wr(32'hA05F_0001, 0, "R3 software set attempt");
    rd("R3 software cannot enable");
    wr(32'hA05F_0003, 1, "R3 debugger enable and halt");
    rd("R2 control readback");

    wr(32'hA05F_000B, 1, "R4 mask while halted");
    rd("R4 mask accepted");
    wr(32'hA05F_0001, 1, "R4 unhalt write clearing mask");
    rd("R4 mask kept when halt cleared");
    wr(32'hA05F_0003, 0, "R4 mask clear when not halted before");
    rd("R4 mask kept when not previously halted");
    wr(32'hA05F_0003, 0, "R4 mask clear while halted");
    rd("R4 mask cleared");
    wr(32'hA05F_0007, 0, "R2 step bit");
    rd("R2 step readback");

    wr(32'hA05F_000E, 0, "R7 software clears enable");
    rd("R7 outputs forced low");
    wr(32'hA05F_0003, 0, "R3 software re-enable attempt");
    rd("R3 still disabled");

    core_retired = 1; tick("R5 retire event");
    rd("R5 retired flag set");
    rd("R5 retired flag cleared");
    core_reset_evt = 1; tick("R5 reset event");
    bus_sel = 1; bus_rd = 1; core_retired = 1; core_reset_evt = 1;
    tick("R6 read with events");
    rd("R6 flags survive read");
    rd("R6 flags cleared");

    xfer_ready = 1; core_sleeping = 1; core_lockup = 1;
    rd("R8 lockup visible when running");
    core_halted = 1;
    rd("R8 lockup hidden when halted");
    xfer_ready = 0; core_sleeping = 0; core_lockup = 0;
    rd("R8 halted only");
    core_halted = 0;
    wr(32'hFFFF_FFF0, 1, "R1 unkeyed all-ones");
    rd("R2 key field reads zero");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule